// File: doc/BRIEF.md
# Eight-bit arithmetic-logic unit with carry and zero flags

This block performs one of ten single-cycle operations on two 8-bit operands and returns an 8-bit result with two flags. The operations are pass-through, add, subtract, bitwise AND, bitwise OR, complement, increment and three single-bit shifts. Complement, increment and the shifts use operand `a` only. Each operation sets the carry flag by its own rule. The zero flag is raised whenever the result byte is all zeros.

Inside the block, one shared adder serves add, subtract and increment. A bitwise unit and a shift unit run beside it, and an output stage selects among the three. By default the output stage is registered, so the outputs for the inputs present at a rising clock edge appear just after that edge. A synchronous active-high reset clears the outputs to result 0, carry 0 and zero 1. Setting the parameter `REG_OUT` to 0 makes the outputs purely combinational.

Top module: `alu8_core`

## Requirements
- R1: Operation code 4'h1 (add) gives result = (a + b) mod 256, and carry is the carry out of bit 7.
- R2: Operation code 4'h2 (subtract) gives result = (a - b) mod 256, and carry (borrow) is 1 exactly when a < b as unsigned values.
- R3: Code 4'h0 gives result = a, code 4'h3 gives result = a AND b, and code 4'h4 gives result = a OR b. Carry is 0 for all three.
- R4: Code 4'h5 (complement) gives result = bitwise NOT of a, and carry is 1.
- R5: Code 4'h6 (increment) gives result = (a + 1) mod 256, and carry is 1 exactly when a = 8'hFF.
- R6: Code 4'h7 (logical right shift) gives result = {0, a[7:1]} and carry = a[0].
- R7: Code 4'h8 (logical left shift) gives result = {a[6:0], 0} and carry = a[7].
- R8: Code 4'h9 (arithmetic right shift) gives result = {a[7], a[7:1]} and carry = a[0].
- R9: For every operation code, zero is 1 exactly when all 8 result bits are 0.
- R10: Codes 4'hA through 4'hF give result 0, carry 0 and zero 1.
- R11: With `REG_OUT`=1, the outputs for the inputs sampled at a rising clock edge appear after that edge, and the outputs hold their value until the next edge. A rising edge with rst high sets result 0, carry 0 and zero 1.
- R12: For codes 4'h5 through 4'h9, a change in b has no effect on result or carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op | input | 4 | Operation select, codes 4'h0 to 4'h9 are valid |
| a | input | 8 | First operand; the only operand for unary ops and shifts |
| b | input | 8 | Second operand |
| result | output | 8 | Operation result |
| carry | output | 1 | Carry, borrow or shifted-out bit, depending on the operation |
| zero | output | 1 | High when result is all zeros |

## Verification
Carry and zero can both be raised in the same cycle, and this is where each flag's logic could mask or corrupt the other. The case is provoked in five ways: add of 8'h80 and 8'h80, increment of 8'hFF, complement of 8'hFF, left shift of 8'h80, and a right shift of 8'h01. Each of these gives a zero result together with a set carry. Each case is judged on the whole output {result, carry, zero} against a value derived from the requirements. Corner operands crossed with every operation code, including the unused codes, and a random sweep check that neither flag leaks into a case where only the other should be set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'h0,
        OP_ADD  = 4'h1,
        OP_SUB  = 4'h2,
        OP_AND  = 4'h3,
        OP_OR   = 4'h4,
        OP_NOT  = 4'h5,
        OP_INC  = 4'h6,
        OP_SHR  = 4'h7,
        OP_SHL  = 4'h8,
        OP_SAR  = 4'h9
    } alu_op_e;

    // One datapath lane: a data byte plus its carry-like flag.
    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              cy;
    } lane_t;

    // Which functional unit owns an operation code.
    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_BITS  = 2'd2,
        GRP_SHIFT = 2'd3
    } alu_grp_e;

    function automatic alu_grp_e op_group(input logic [OP_W-1:0] op);
        alu_grp_e g;
        case (op)
            OP_ADD, OP_SUB, OP_INC:         g = GRP_ARITH;
            OP_PASS, OP_AND, OP_OR, OP_NOT: g = GRP_BITS;
            OP_SHR, OP_SHL, OP_SAR:         g = GRP_SHIFT;
            default:                        g = GRP_NONE;
        endcase
        return g;
    endfunction

    localparam lane_t LANE_ZERO = '{val: '0, cy: 1'b0};

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output lane_t             res
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [SUM_W-1:0]  sum;
    logic              is_sub;
    logic              is_inc;

    assign is_sub = (op == OP_SUB);
    assign is_inc = (op == OP_INC);

    // Single shared adder: add uses b, subtract uses ~b + 1, increment uses 0 + 1.
    always_comb begin
        if (is_sub) begin
            addend = ~b;
        end else if (is_inc) begin
            addend = '0;
        end else begin
            addend = b;
        end
        cin = is_sub | is_inc;
    end

    assign sum = {1'b0, a} + {1'b0, addend} + {{(SUM_W-1){1'b0}}, cin};

    // Borrow is the inverse of the adder carry when subtracting.
    assign res.val = sum[DATA_W-1:0];
    assign res.cy  = is_sub ? ~sum[DATA_W] : sum[DATA_W];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output lane_t             res
);
    always_comb begin
        res = LANE_ZERO;
        case (op)
            OP_PASS: res.val = a;
            OP_AND:  res.val = a & b;
            OP_OR:   res.val = a | b;
            OP_NOT: begin
                res.val = ~a;
                res.cy  = 1'b1;
            end
            default: res = LANE_ZERO;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    output lane_t             res
);
    localparam int MSB = DATA_W - 1;

    logic fill_hi;

    // Right shifts differ only in the bit entering at the top.
    assign fill_hi = (op == OP_SAR) ? a[MSB] : 1'b0;

    always_comb begin
        res = LANE_ZERO;
        case (op)
            OP_SHR, OP_SAR: begin
                res.val = {fill_hi, a[MSB:1]};
                res.cy  = a[0];
            end
            OP_SHL: begin
                res.val = {a[MSB-1:0], 1'b0};
                res.cy  = a[MSB];
            end
            default: res = LANE_ZERO;
        endcase
    end

endmodule

// File: rtl/alu8_outstage.sv
module alu8_outstage
    import alu8_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  lane_t             arith_res,
    input  lane_t             bits_res,
    input  lane_t             shift_res,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero
);
    lane_t sel;
    logic  zero_n;

    always_comb begin
        case (op_group(op))
            GRP_ARITH: sel = arith_res;
            GRP_BITS:  sel = bits_res;
            GRP_SHIFT: sel = shift_res;
            default:   sel = LANE_ZERO;
        endcase
    end

    assign zero_n = ~|sel.val;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    result <= '0;
                    carry  <= 1'b0;
                    zero   <= 1'b1;
                end else begin
                    result <= sel.val;
                    carry  <= sel.cy;
                    zero   <= zero_n;
                end
            end
        end else begin : g_comb
            assign result = sel.val;
            assign carry  = sel.cy;
            assign zero   = zero_n;
        end
    endgenerate

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero
);
    lane_t arith_res;
    lane_t bits_res;
    lane_t shift_res;

    alu8_arith u_arith (
        .op  (op),
        .a   (a),
        .b   (b),
        .res (arith_res)
    );

    alu8_logic u_bits (
        .op  (op),
        .a   (a),
        .b   (b),
        .res (bits_res)
    );

    alu8_shift u_shift (
        .op  (op),
        .a   (a),
        .res (shift_res)
    );

    alu8_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .arith_res (arith_res),
        .bits_res  (bits_res),
        .shift_res (shift_res),
        .result    (result),
        .carry     (carry),
        .zero      (zero)
    );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] result,
    input logic              carry,
    input logic              zero
);
    localparam int MSB = DATA_W - 1;

    // Inputs aligned with the outputs they produced.
    logic [OP_W-1:0]   op_v;
    logic [DATA_W-1:0] a_v;
    logic [DATA_W-1:0] b_v;

    generate
        if (REG_OUT) begin : g_align
            always_ff @(posedge clk) begin
                if (rst) begin
                    op_v <= '0;
                    a_v  <= '0;
                    b_v  <= '0;
                end else begin
                    op_v <= op;
                    a_v  <= a;
                    b_v  <= b;
                end
            end
        end else begin : g_direct
            assign op_v = op;
            assign a_v  = a;
            assign b_v  = b;
        end
    endgenerate

    p_add_r1: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_ADD) |-> ({carry, result} == ({1'b0, a_v} + {1'b0, b_v})));

    p_sub_r2: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_SUB) |-> (carry == (a_v < b_v)) && (result == DATA_W'(a_v - b_v)));

    p_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_AND || op_v == OP_OR || op_v == OP_PASS) |-> !carry);

    p_not_r4: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_NOT) |-> carry && (result == ~a_v));

    p_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_INC) |-> (carry == (&a_v)) && (result == DATA_W'(a_v + 1'b1)));

    p_shr_r6: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_SHR) |-> (carry == a_v[0]) && !result[MSB] && (result[MSB-1:0] == a_v[MSB:1]));

    p_shl_r7: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_SHL) |-> (carry == a_v[MSB]) && !result[0] && (result[MSB:1] == a_v[MSB-1:0]));

    p_sar_r8: assert property (@(posedge clk) disable iff (rst)
        (op_v == OP_SAR) |-> (carry == a_v[0]) && (result[MSB] == a_v[MSB]) && (result[MSB-1:0] == a_v[MSB:1]));

    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        zero == (result == '0));

    p_unused_r10: assert property (@(posedge clk) disable iff (rst)
        (op_v > OP_SAR) |-> (result == '0) && !carry && zero);

endmodule

bind alu8_core alu8_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .a      (a),
    .b      (b),
    .result (result),
    .carry  (carry),
    .zero   (zero)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;
    localparam int N_VEC = 25;
    localparam int N_RAND = 200;

    // {op[29:26], a[25:18], b[17:10], result[9:2], carry[1], zero[0]}
    localparam logic [29:0] VEC [N_VEC] = '{
        {4'h1, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
        {4'h1, 8'h0F, 8'h01, 8'h10, 1'b0, 1'b0},
        {4'h1, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},
        {4'h2, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1},
        {4'h2, 8'h00, 8'h01, 8'hFF, 1'b1, 1'b0},
        {4'h2, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b0},
        {4'h3, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},
        {4'h3, 8'hAA, 8'h55, 8'h00, 1'b0, 1'b1},
        {4'h4, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1},
        {4'h4, 8'hA0, 8'h05, 8'hA5, 1'b0, 1'b0},
        {4'h0, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1},
        {4'h0, 8'h81, 8'h00, 8'h81, 1'b0, 1'b0},
        {4'h5, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},
        {4'h5, 8'h5A, 8'h00, 8'hA5, 1'b1, 1'b0},
        {4'h6, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},
        {4'h6, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b0},
        {4'h7, 8'h01, 8'h00, 8'h00, 1'b1, 1'b1},
        {4'h7, 8'h80, 8'h00, 8'h40, 1'b0, 1'b0},
        {4'h8, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1},
        {4'h8, 8'h41, 8'h00, 8'h82, 1'b0, 1'b0},
        {4'h9, 8'h81, 8'h00, 8'hC0, 1'b1, 1'b0},
        {4'h9, 8'h01, 8'h00, 8'h00, 1'b1, 1'b1},
        {4'h9, 8'h7E, 8'h00, 8'h3F, 1'b0, 1'b0},
        {4'hA, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b1},
        {4'hF, 8'h80, 8'h01, 8'h00, 1'b0, 1'b1}
    };

    localparam logic [7:0] CORNERS [4] = '{8'h00, 8'hFF, 8'h80, 8'h01};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op  = 4'h0;
    logic [7:0] a   = 8'h00;
    logic [7:0] b   = 8'h00;
    logic [7:0] result;
    logic       carry;
    logic       zero;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    alu8_core dut (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .a      (a),
        .b      (b),
        .result (result),
        .carry  (carry),
        .zero   (zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirement list: {result, carry, zero}.
    function automatic logic [9:0] ref_alu(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y);
        logic [7:0] r;
        logic       c;
        logic [8:0] s;
        r = 8'h00;
        c = 1'b0;
        case (o)
            4'h0: r = x;
            4'h1: begin s = {1'b0, x} + {1'b0, y}; r = s[7:0]; c = s[8]; end
            4'h2: begin r = x - y; c = (x < y); end
            4'h3: r = x & y;
            4'h4: r = x | y;
            4'h5: begin r = ~x; c = 1'b1; end
            4'h6: begin r = x + 8'h01; c = (x == 8'hFF); end
            4'h7: begin r = x >> 1; c = x[0]; end
            4'h8: begin r = x << 1; c = x[7]; end
            4'h9: begin r = {x[7], x[7:1]}; c = x[0]; end
            default: begin r = 8'h00; c = 1'b0; end
        endcase
        return {r, c, (r == 8'h00)};
    endfunction

    function automatic string req_tag(input logic [3:0] o);
        case (o)
            4'h0, 4'h3, 4'h4: return "R3/R9";
            4'h1: return "R1/R9";
            4'h2: return "R2/R9";
            4'h5: return "R4/R9";
            4'h6: return "R5/R9";
            4'h7: return "R6/R9";
            4'h8: return "R7/R9";
            4'h9: return "R8/R9";
            default: return "R10/R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register stage).
    task automatic run_op(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                          input logic [9:0] exp, input string tag);
        logic [9:0] act;
        @(negedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        act = {result, carry, zero};
        check(act == exp, tag, act, exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [9:0] snap;
        logic [9:0] act;

        // R11: reset state, with inputs that would otherwise give a non-zero result
        op = 4'h5; a = 8'h00; b = 8'h00;
        repeat (3) @(negedge clk);
        act = {result, carry, zero};
        check(act == {8'h00, 1'b0, 1'b1}, "R11 reset state", act, {8'h00, 1'b0, 1'b1});
        rst = 1'b0;

        // Vector table: R1..R10 and the carry-with-zero cases
        for (int i = 0; i < N_VEC; i++) begin
            run_op(VEC[i][29:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:0],
                   req_tag(VEC[i][29:26]));
        end

        // Corner operands crossed with every operation code
        for (int o = 0; o < 16; o++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    run_op(4'(o), CORNERS[i], CORNERS[j],
                           ref_alu(4'(o), CORNERS[i], CORNERS[j]), req_tag(4'(o)));
                end
            end
        end

        // Random sweep over every operation code
        for (int o = 0; o < 16; o++) begin
            for (int k = 0; k < N_RAND; k++) begin
                logic [7:0] rx;
                logic [7:0] ry;
                rx = 8'($urandom);
                ry = 8'($urandom);
                run_op(4'(o), rx, ry, ref_alu(4'(o), rx, ry), req_tag(4'(o)));
            end
        end

        // R12: b has no effect on unary and shift operations
        for (int o = 5; o < 10; o++) begin
            run_op(4'(o), 8'h3C, 8'h00, ref_alu(4'(o), 8'h3C, 8'h00), req_tag(4'(o)));
            snap = {result, carry, zero};
            @(negedge clk);
            b = 8'hFF;
            @(negedge clk);
            act = {result, carry, zero};
            check(act == snap, "R12 b ignored", act, snap);
        end

        // R11: output holds before the edge and updates after it
        run_op(4'h1, 8'h01, 8'h01, {8'h02, 1'b0, 1'b0}, "R11 setup");
        @(negedge clk);
        op = 4'h5; a = 8'h0F; b = 8'h00;
        #1;
        act = {result, carry, zero};
        check(act == {8'h02, 1'b0, 1'b0}, "R11 hold before edge", act, {8'h02, 1'b0, 1'b0});
        @(posedge clk);
        #1;
        act = {result, carry, zero};
        check(act == {8'hF0, 1'b1, 1'b0}, "R11 update after edge", act, {8'hF0, 1'b1, 1'b0});

        // R11: reset in mid-run clears the outputs
        @(negedge clk);
        rst = 1'b1;
        op = 4'h5; a = 8'h00;
        @(negedge clk);
        act = {result, carry, zero};
        check(act == {8'h00, 1'b0, 1'b1}, "R11 mid-run reset", act, {8'h00, 1'b0, 1'b1});
        rst = 1'b0;
        @(negedge clk);
        act = {result, carry, zero};
        check(act == {8'hFF, 1'b1, 1'b0}, "R11 resume after reset", act, {8'hFF, 1'b1, 1'b0});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule